// File: doc/BRIEF.md
# Dual-Channel Down-Counting Reload Timer

A register-mapped timer with two independent down-counting channels. Each channel owns a control word, a writable fixed (reload) count and a read-only running count. Channel 0 is meant to be armed as a one-shot event timer that raises an interrupt when it expires. Channel 1 is meant to run as a free-running time base that reloads itself from its fixed count. Each channel's control word can be changed bit by bit through set, clear and toggle alias addresses. This avoids read-modify-write sequences between software contexts.

Each channel picks its own tick: either every clock, or a slow tick-enable input that is sampled on the block clock. Any other select value freezes the channel. One interrupt line combines every channel. A write to the global control word can return all channels to their reset state.

The register port is a plain synchronous strobe interface and never applies back-pressure. A write completes on the clock edge where `wr_en` is high. A read strobed by `rd_en` presents its data on `rdata` after that edge. `rdata` holds its value until the next read.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset every channel's control word, running count and fixed count read 0, and `irq` is low.
- R2: Channel n's control word sits at 0x20 + n*0x40. A write at +0x0 replaces it, +0x4 ORs `wdata` in, +0x8 clears the bits set in `wdata`, and +0xC toggles them. A read at any of the four addresses returns the word. Implemented bits: tick select [3:0], RELOAD bit 6, UPDATE bit 7, IRQ enable bit 14, IRQ flag bit 15. All other bits read 0.
- R3: Tick select 0xF decrements on every clock. Select 0xB decrements on each clock where `slow_tick` is high. Any other select value leaves the running count unchanged.
- R4: The running count decreases by one per tick. Without RELOAD it stops at 0 and stays there.
- R5: Writing the fixed count (0x40 + n*0x40) while UPDATE is set also loads the running count on the same edge. While UPDATE is clear, only the fixed count changes.
- R6: With RELOAD set, a tick at running count 1 loads the running count from the fixed count instead of 0.
- R7: A tick at running count 1 sets the IRQ flag (bit 15). This takes priority over a clear written on the same edge.
- R8: `irq` is high exactly when some channel has both its IRQ enable and its IRQ flag set.
- R9: Writing bit 31 = 1 to the global control word at 0x00 (base, set or toggle alias) clears every channel's registers. The global word reads 0.
- R10: The version register at 0x120 reads 0x02000000 (major version 2 in bits 31:24). Unmapped addresses read 0. `rdata` changes only after a read strobe.
- R11: The running count at 0x30 + n*0x40 is read-only. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Slow tick enable, one clock wide per tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (9) | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: two channels, 32-bit counts and a 9-bit address. With these values both channel windows, the global word and the version register at 0x120 are all reachable. Because the bench drives the slow tick itself, and because fixed counts are small, expiry, reload and the flag-versus-clear collision can be placed on exact edges within a few cycles. Counter wrap at the full 32-bit width is out of reach at these settings.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } ctl_op_e;

  localparam int SEL_W      = 4;
  localparam int BIT_RELOAD = 6;
  localparam int BIT_UPDATE = 7;
  localparam int BIT_IRQEN  = 14;
  localparam int BIT_IRQ    = 15;
  localparam int BIT_SRST   = 31;

  localparam logic [SEL_W-1:0] SEL_ALWAYS = 4'hF;
  localparam logic [SEL_W-1:0] SEL_SLOW   = 4'hB;

  localparam logic [31:0] CTL_MASK    = 32'h0000_C0CF;
  localparam logic [31:0] VERSION_VAL = 32'h0200_0000;

  localparam int CTL_BASE  = 'h20;
  localparam int CNT_BASE  = 'h30;
  localparam int FIX_BASE  = 'h40;
  localparam int CH_STRIDE = 'h40;
  localparam int VER_ADDR  = 'h120;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             slow_tick,
  output logic             tick
);
  always_comb begin
    unique case (sel)
      SEL_ALWAYS: tick = 1'b1;
      SEL_SLOW:   tick = slow_tick;
      default:    tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] hit_ctl,
  output logic [NUM_CH-1:0] hit_cnt,
  output logic [NUM_CH-1:0] hit_fix,
  output logic              hit_gctl,
  output logic              hit_ver,
  output ctl_op_e           op
);
  localparam int HI = ADDR_W - 1;

  assign op       = ctl_op_e'(addr[3:2]);
  assign hit_gctl = (addr[HI:4] == '0) && (addr[1:0] == 2'b00);
  assign hit_ver  = (addr == ADDR_W'(VER_ADDR));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam logic [ADDR_W-1:0] CB = ADDR_W'(CTL_BASE + n * CH_STRIDE);
    localparam logic [ADDR_W-1:0] RB = ADDR_W'(CNT_BASE + n * CH_STRIDE);
    localparam logic [ADDR_W-1:0] FB = ADDR_W'(FIX_BASE + n * CH_STRIDE);
    assign hit_ctl[n] = (addr[HI:4] == CB[HI:4]) && (addr[1:0] == 2'b00);
    assign hit_cnt[n] = (addr == RB);
    assign hit_fix[n] = (addr == FB);
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             slow_tick,
  input  logic             ctl_we,
  input  ctl_op_e          ctl_op,
  input  logic             fix_we,
  input  logic [31:0]      wdata,
  output logic [31:0]      ctrl_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] fix_q,
  output logic             irq_req
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [31:0] ctl_wr;
  logic [31:0] ctl_d;
  logic        tick;
  logic        load_now;
  logic        expire;
  logic        reload_en;

  tmr_tick_sel u_tick (
    .sel       (ctrl_q[SEL_W-1:0]),
    .slow_tick (slow_tick),
    .tick      (tick)
  );

  assign reload_en = ctrl_q[BIT_RELOAD];
  assign load_now  = fix_we && ctrl_q[BIT_UPDATE];
  assign expire    = tick && (cnt_q == ONE) && !load_now;

  always_comb begin
    unique case (ctl_op)
      OP_WRITE: ctl_wr = wdata;
      OP_SET:   ctl_wr = ctrl_q | wdata;
      OP_CLR:   ctl_wr = ctrl_q & ~wdata;
      default:  ctl_wr = ctrl_q ^ wdata;
    endcase
    ctl_d = ctl_we ? (ctl_wr & CTL_MASK) : ctrl_q;
    if (expire) ctl_d[BIT_IRQ] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_clr) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      fix_q  <= '0;
    end else begin
      ctrl_q <= ctl_d;
      if (fix_we) fix_q <= wdata[CNT_W-1:0];
      if (load_now) begin
        cnt_q <= wdata[CNT_W-1:0];
      end else if (tick) begin
        if (cnt_q == '0) begin
          if (reload_en) cnt_q <= fix_q;
        end else if (cnt_q == ONE) begin
          cnt_q <= reload_en ? fix_q : '0;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign irq_req = ctrl_q[BIT_IRQEN] && ctrl_q[BIT_IRQ];

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && !load_now && tick && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && !load_now && !tick) |=> $stable(cnt_q));

  p_stop_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && !load_now && cnt_q == '0 && !reload_en) |=> cnt_q == '0);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && !load_now && tick && cnt_q == ONE && reload_en) |=> cnt_q == $past(fix_q));

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && !load_now && tick && cnt_q == ONE) |=> ctrl_q[BIT_IRQ]);

  p_update_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && load_now) |=> cnt_q == fix_q);
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  logic [NUM_CH-1:0] hit_ctl, hit_cnt, hit_fix;
  logic              hit_gctl, hit_ver;
  ctl_op_e           op;
  logic              soft_clr;
  logic              any_hit;
  logic [31:0]       rd_val;

  logic [NUM_CH-1:0][31:0]      ctl_rd;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_rd;
  logic [NUM_CH-1:0][CNT_W-1:0] fix_rd;
  logic [NUM_CH-1:0]            irq_req;

  tmr_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr     (addr),
    .hit_ctl  (hit_ctl),
    .hit_cnt  (hit_cnt),
    .hit_fix  (hit_fix),
    .hit_gctl (hit_gctl),
    .hit_ver  (hit_ver),
    .op       (op)
  );

  assign soft_clr = wr_en && hit_gctl && wdata[BIT_SRST] && (op != OP_CLR);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_clr  (soft_clr),
      .slow_tick (slow_tick),
      .ctl_we    (wr_en && hit_ctl[n]),
      .ctl_op    (op),
      .fix_we    (wr_en && hit_fix[n]),
      .wdata     (wdata),
      .ctrl_q    (ctl_rd[n]),
      .cnt_q     (cnt_rd[n]),
      .fix_q     (fix_rd[n]),
      .irq_req   (irq_req[n])
    );
  end

  assign any_hit = hit_ver || (|hit_ctl) || (|hit_cnt) || (|hit_fix);

  always_comb begin
    rd_val = '0;
    if (hit_ver) rd_val = VERSION_VAL;
    for (int n = 0; n < NUM_CH; n++) begin
      if (hit_ctl[n]) rd_val = ctl_rd[n];
      if (hit_cnt[n]) rd_val = 32'(cnt_rd[n]);
      if (hit_fix[n]) rd_val = 32'(fix_rd[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  assign irq = |irq_req;

  p_srst_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !irq);

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !any_hit) |=> rdata == '0);

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/tb_dual_reload_timer.sv
`timescale 1ns/1ps
module tb_dual_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dual_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [8:0]  a;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 9'h120, 32'h0200_0000},  // R10 version
    '{1'b1, 9'h020, 32'h0000_40C0},  // R2 base write
    '{1'b0, 9'h020, 32'h0000_40C0},
    '{1'b1, 9'h028, 32'h0000_0040},  // R2 clear alias
    '{1'b0, 9'h024, 32'h0000_4080},
    '{1'b1, 9'h024, 32'h0000_0003},  // R2 set alias
    '{1'b0, 9'h028, 32'h0000_4083},
    '{1'b1, 9'h02C, 32'h0000_4001},  // R2 toggle alias
    '{1'b0, 9'h02C, 32'h0000_0082},
    '{1'b1, 9'h020, 32'hFFFF_3F30},  // R2 unimplemented bits
    '{1'b0, 9'h020, 32'h0000_0000},
    '{1'b1, 9'h040, 32'h0000_1234},  // R5 no UPDATE
    '{1'b0, 9'h040, 32'h0000_1234},
    '{1'b0, 9'h030, 32'h0000_0000},
    '{1'b1, 9'h030, 32'h0000_DEAD},  // R11 read-only count
    '{1'b0, 9'h030, 32'h0000_0000},
    '{1'b1, 9'h060, 32'h0000_0080},  // R5 UPDATE on channel 1
    '{1'b1, 9'h080, 32'h0000_0055},
    '{1'b0, 9'h070, 32'h0000_0055},
    '{1'b0, 9'h080, 32'h0000_0055},
    '{1'b0, 9'h1F0, 32'h0000_0000},  // R10 unmapped
    '{1'b0, 9'h000, 32'h0000_0000}   // R9 global word reads 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string req);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    chk(req, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    slow_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    slow_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(9'h060, 32'h0, "R1 ctrl1");
    rd(9'h070, 32'h0, "R1 count1");
    rd(9'h040, 32'h0, "R1 fixed0");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].a, VEC[i].d);
      else rd(VEC[i].a, VEC[i].d, $sformatf("vector %0d", i));
    end

    // R3 R4 R5: every-clock tick on channel 0
    wr(9'h020, 32'h0000_008F);
    wr(9'h040, 32'd10);
    rd(9'h030, 32'd10, "R5 update load");
    idle(3);
    rd(9'h030, 32'd6, "R3 always tick");
    idle(10);
    rd(9'h030, 32'd0, "R4 stop at zero");
    rd(9'h020, 32'h0000_808F, "R7 flag on expiry");
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(9'h024, 32'h0000_4000);
    chk("R8 irq raised", {31'b0, irq}, 32'h1);
    wr(9'h028, 32'h0000_8000);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);

    // R3 R6 R7: slow tick with reload on channel 1
    wr(9'h060, 32'h0000_00CB);
    wr(9'h080, 32'd3);
    idle(5);
    rd(9'h070, 32'd3, "R3 slow tick idle");
    pulse_tick();
    pulse_tick();
    rd(9'h070, 32'd1, "R4 slow decrement");
    slow_tick = 1'b1;
    wr(9'h068, 32'h0000_8000);
    slow_tick = 1'b0;
    rd(9'h060, 32'h0000_80CB, "R7 flag beats clear");
    rd(9'h070, 32'd3, "R6 reload");
    wr(9'h064, 32'h0000_4000);
    chk("R8 irq channel1", {31'b0, irq}, 32'h1);

    // R9 soft reset through the set alias
    wr(9'h004, 32'h8000_0000);
    chk("R9 irq after soft reset", {31'b0, irq}, 32'h0);
    rd(9'h060, 32'h0, "R9 ctrl1");
    rd(9'h080, 32'h0, "R9 fixed1");
    rd(9'h040, 32'h0, "R9 fixed0");

    // R3 other select value freezes the count
    wr(9'h060, 32'h0000_0085);
    wr(9'h080, 32'd7);
    idle(4);
    pulse_tick();
    rd(9'h070, 32'd7, "R3 frozen select");

    finish_run();
  end
endmodule